// File: doc/BRIEF.md
# Keyed Shutdown and Wake-up Controller

This block runs on the always-on slow clock (32768 Hz) and drives a single shutdown output that removes main power from the rest of the chip. Software requests shutdown by writing a control word. The request is accepted only when the top byte of that word carries the unlock value 0xA5. While the output is asserted, the block watches up to sixteen external wake pins and two alarm inputs. One alarm comes from the calendar clock and the other from the interval timer.

Each wake pin has its own enable and its own active level. Each pin passes through a two-flop synchronizer and then through a debouncer. The debouncer counts how long the pin has held its active level, against a period picked from a fixed table of slow-clock counts. When any enabled source qualifies, shutdown is released and the cause is latched into a status word. The status word stays until software reads it, and that read clears it. An all-zero status therefore means a plain power-on.

Top module: `shdn_ctrl`

## Requirements
- R1: After reset the shutdown output is low and all four registers read as zero. A zero status means no wake has been recorded.
- R2: A write to offset 0x00 with bit 0 set and bits 31:24 equal to 0xA5 raises the shutdown output on the next clock edge. A write with the key but bit 0 clear does nothing. Offset 0x00 always reads as zero.
- R3: A write to offset 0x00 whose bits 31:24 differ from 0xA5 is ignored. The shutdown output and every register keep their values.
- R4: At offset 0x04, bits 26:24 select the debounce length. Codes 0 to 5 select 0, 3, 32, 512, 4096 and 32768 cycles, and codes 6 and 7 select 32768. Bit 17 enables calendar-alarm wake and bit 16 enables interval-alarm wake. Only these bits are stored, and all other bits read as zero.
- R5: At offset 0x0C, bit n (n = 0..15) enables wake pin n. Bit 16+n selects the active level of pin n: 1 means high and 0 means low. All 32 bits read back as written.
- R6: An enabled pin qualifies only after its active level, seen through the two-flop synchronizer, has held for the selected length without a break. A pin that becomes active before clock edge e0 releases shutdown at edge e(2+P), where P is the selected length; with P = 0 this is edge e2. A break in the active level restarts the count.
- R7: While shutdown is asserted, a qualified pin or an enabled alarm releases it on the next edge. The status word latches the cause: bit 16+n for pin n, bit 5 for the calendar alarm and bit 6 for the interval alarm.
- R8: Reads return data one cycle after the read strobe. A read of the status word at offset 0x08 returns the latched cause and clears it. The status word holds its value until it is read. A wake condition while shutdown is not asserted leaves the status word unchanged.
- R9: Disabled pins and disabled alarms never release shutdown. Writing zero to offsets 0x04 and 0x0C disables every wake source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| wake_pin | input | NPIN | Asynchronous wake pins |
| rtc_alarm | input | 1 | Calendar alarm request |
| rtt_alarm | input | 1 | Interval timer alarm request |
| shdn_out | output | 1 | Shutdown request to the power switch |

## Verification
The assertions assume that reads and writes are single-cycle strobes that are never raised together. They also assume that the debounce code does not change while a pin is being counted. The stimulus follows both assumptions: bus tasks raise exactly one strobe for one cycle, and the mode register is written only while every pin sits at its inactive level. Pins and alarms change only at falling edges and are held for whole cycles. This keeps the release edge predictable to the exact cycle.

// File: rtl/shdn_pkg.sv
package shdn_pkg;
  localparam logic [7:0] UNLOCK_KEY = 8'hA5;
  localparam int OFS_CTRL = 'h0;
  localparam int OFS_MODE = 'h4;
  localparam int OFS_STAT = 'h8;
  localparam int OFS_WCFG = 'hC;
  localparam int STAT_RTC_BIT = 5;
  localparam int STAT_RTT_BIT = 6;
  localparam int STAT_PIN_LSB = 16;

  // debounce length table, in slow-clock cycles
  function automatic logic [15:0] dbc_cycles(input logic [2:0] code);
    case (code)
      3'd0:    return 16'd0;
      3'd1:    return 16'd3;
      3'd2:    return 16'd32;
      3'd3:    return 16'd512;
      3'd4:    return 16'd4096;
      default: return 16'd32768;
    endcase
  endfunction
endpackage

// File: rtl/shdn_sync.sv
module shdn_sync #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/shdn_debounce.sv
module shdn_debounce #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_i,
  input  logic [CNT_W-1:0] per_i,
  output logic             ok_o
);
  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !act_i) run_q <= '0;
    else if (run_q < per_i) run_q <= run_q + 1'b1;
  end

  assign ok_o = act_i && ((per_i == '0) || (run_q >= per_i));

  // R6: a counted qualification needs the level to have been active one cycle earlier
  p_dbc_held_r6: assert property (@(posedge clk) disable iff (rst)
    (ok_o && per_i != '0) |-> $past(act_i));
endmodule

// File: rtl/shdn_ctrl.sv
module shdn_ctrl
  import shdn_pkg::*;
#(
  parameter int NPIN    = 16,
  parameter int ADDR_W  = 4,
  parameter int HAS_RTT = 1,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [NPIN-1:0]   wake_pin,
  input  logic              rtc_alarm,
  input  logic              rtt_alarm,
  output logic              shdn_out
);
  localparam int SW = NPIN + 2;

  logic [2:0]      dbc_code_q;
  logic            rtc_en_q, rtt_en_q;
  logic [NPIN-1:0] pin_en_q, pin_pol_q;
  logic [31:0]     stat_q;
  logic            shdn_q;

  logic [SW-1:0]    sync_q;
  logic [NPIN-1:0]  pin_ok;
  logic [CNT_W-1:0] per;
  logic [31:0]      cause;
  logic             any_wake;

  logic sel_ctrl, sel_mode, sel_stat, sel_wcfg;
  assign sel_ctrl = (addr == ADDR_W'(OFS_CTRL));
  assign sel_mode = (addr == ADDR_W'(OFS_MODE));
  assign sel_stat = (addr == ADDR_W'(OFS_STAT));
  assign sel_wcfg = (addr == ADDR_W'(OFS_WCFG));

  shdn_sync #(.W(SW)) u_sync (
    .clk(clk), .rst(rst),
    .d_i({rtt_alarm, rtc_alarm, wake_pin}),
    .q_o(sync_q)
  );

  assign per = CNT_W'(dbc_cycles(dbc_code_q));

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic act;
    assign act = pin_en_q[i] & ~(sync_q[i] ^ pin_pol_q[i]);
    shdn_debounce #(.CNT_W(CNT_W)) u_dbc (
      .clk(clk), .rst(rst), .act_i(act), .per_i(per), .ok_o(pin_ok[i])
    );
  end

  always_comb begin
    cause = '0;
    cause[STAT_PIN_LSB +: NPIN] = pin_ok;
    cause[STAT_RTC_BIT] = sync_q[NPIN] & rtc_en_q;
    cause[STAT_RTT_BIT] = (HAS_RTT != 0) & sync_q[NPIN+1] & rtt_en_q;
  end
  assign any_wake = |cause;

  always_ff @(posedge clk) begin
    if (rst) begin
      dbc_code_q <= '0;
      rtc_en_q   <= 1'b0;
      rtt_en_q   <= 1'b0;
      pin_en_q   <= '0;
      pin_pol_q  <= '0;
      stat_q     <= '0;
      shdn_q     <= 1'b0;
    end else begin
      if (wr_en) begin
        if (sel_ctrl && wdata[31:24] == UNLOCK_KEY && wdata[0]) shdn_q <= 1'b1;
        if (sel_mode) begin
          dbc_code_q <= wdata[26:24];
          rtc_en_q   <= wdata[17];
          rtt_en_q   <= (HAS_RTT != 0) && wdata[16];
        end
        if (sel_wcfg) begin
          pin_en_q  <= wdata[NPIN-1:0];
          pin_pol_q <= wdata[16 +: NPIN];
        end
      end
      if (shdn_q && any_wake) begin
        shdn_q <= 1'b0;
        stat_q <= cause;
      end else if (rd_en && sel_stat) begin
        stat_q <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      rdata <= '0;
      if (sel_mode) rdata <= {5'd0, dbc_code_q, 6'd0, rtc_en_q, rtt_en_q, 16'd0};
      if (sel_stat) rdata <= stat_q;
      if (sel_wcfg) rdata <= {16'(pin_pol_q), 16'(pin_en_q)};
    end
  end

  assign shdn_out = shdn_q;

  // R3: a write with the wrong key never moves the shutdown state
  p_badkey_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel_ctrl && wdata[31:24] != UNLOCK_KEY && !any_wake) |=> $stable(shdn_out));
  // R7: an enabled cause during shutdown releases it and leaves a nonzero status
  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    (shdn_out && any_wake) |=> (!shdn_out && stat_q != 32'd0));
  // R8: status only changes on a wake in shutdown or on a status read
  p_stat_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!(shdn_out && any_wake) && !(rd_en && sel_stat)) |=> $stable(stat_q));
  // R9: with nothing enabled shutdown cannot drop
  p_no_src_r9: assert property (@(posedge clk) disable iff (rst)
    (shdn_out && pin_en_q == '0 && !rtc_en_q && !rtt_en_q) |=> shdn_out);
endmodule

// File: tb/shdn_ctrl_test.sv
module shdn_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] wake_pin = '0;
  logic        rtc_alarm = 1'b0, rtt_alarm = 1'b0;
  logic        shdn_out;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  shdn_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wake_pin(wake_pin),
    .rtc_alarm(rtc_alarm), .rtt_alarm(rtt_alarm), .shdn_out(shdn_out)
  );

  function automatic int dbc_len(input int code);
    case (code)
      0: return 0;
      1: return 3;
      2: return 32;
      3: return 512;
      4: return 4096;
      default: return 32768;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // caller has just changed a source at a falling edge
  task automatic expect_release(input string req, input int p);
    repeat (p + 2) @(negedge clk);
    check({req, " still shut"}, 32'(shdn_out), 32'd1);
    @(negedge clk);
    check({req, " released"}, 32'(shdn_out), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int unsigned seed;
    seed = 32'd7;
    v = $urandom(seed);
    idle(3);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 shdn", 32'(shdn_out), 32'd0);
    rd(4'h0, v); check("R1 ctrl", v, 0);
    rd(4'h4, v); check("R1 mode", v, 0);
    rd(4'h8, v); check("R1 stat", v, 0);
    rd(4'hC, v); check("R1 wcfg", v, 0);

    // R4 mode readback, R5 wake config readback
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, v); check("R4 mode mask", v, 32'h0703_0000);
    wr(4'hC, 32'hA5A5_1234);
    rd(4'hC, v); check("R5 wcfg readback", v, 32'hA5A5_1234);

    // R3 wrong key
    wr(4'h0, 32'h5A00_0001);
    check("R3 bad key shdn", 32'(shdn_out), 32'd0);
    rd(4'h4, v); check("R3 mode kept", v, 32'h0703_0000);
    rd(4'hC, v); check("R3 wcfg kept", v, 32'hA5A5_1234);

    // R9 everything disabled
    wr(4'h4, 0); wr(4'hC, 0);
    // R2 key without bit 0, then a valid request
    wr(4'h0, 32'hA500_0000);
    check("R2 no bit0", 32'(shdn_out), 32'd0);
    wr(4'h0, 32'hA500_0001);
    check("R2 shdn set", 32'(shdn_out), 32'd1);
    rd(4'h0, v); check("R2 ctrl reads zero", v, 0);
    wake_pin = 16'hFFFF; rtc_alarm = 1'b1; rtt_alarm = 1'b1; idle(8);
    wake_pin = 16'h0000; idle(8);
    check("R9 disabled stays shut", 32'(shdn_out), 32'd1);
    rtc_alarm = 1'b0; rtt_alarm = 1'b0; idle(4);
    rd(4'h8, v); check("R9 status zero", v, 0);

    // R7 calendar alarm
    wr(4'h4, 32'h0002_0000);
    rtc_alarm = 1'b1;
    expect_release("R7 rtc", 0);
    rtc_alarm = 1'b0;
    idle(5);
    rd(4'h8, v); check("R8 status held rtc", v, 32'h20);
    rd(4'h8, v); check("R8 status cleared", v, 0);

    // R7 interval alarm
    wr(4'h4, 32'h0001_0000); idle(3);
    wr(4'h0, 32'hA500_0001);
    rtt_alarm = 1'b1;
    expect_release("R7 rtt", 0);
    rtt_alarm = 1'b0; idle(3);
    rd(4'h8, v); check("R7 rtt cause", v, 32'h40);

    // R6 glitch shorter than 32 cycles is rejected, then full hold qualifies
    wr(4'h4, 32'h0200_0000);
    wr(4'hC, 32'h0008_0008);
    wr(4'h0, 32'hA500_0001);
    wake_pin[3] = 1'b1; idle(20);
    wake_pin[3] = 1'b0; idle(40);
    check("R6 glitch rejected", 32'(shdn_out), 32'd1);
    wake_pin[3] = 1'b1;
    expect_release("R6 32 cycles", 32);
    rd(4'h8, v); check("R7 pin3 cause", v, 32'h0008_0000);

    // R8 wake while running does not touch status
    wake_pin[3] = 1'b0; idle(4);
    wake_pin[3] = 1'b1; idle(40);
    rd(4'h8, v); check("R8 no status when running", v, 0);
    wake_pin[3] = 1'b0; idle(4);

    // R4 long codes: 4096 and code 6 (32768)
    wr(4'h4, 32'h0400_0000);
    wr(4'h0, 32'hA500_0001);
    wake_pin[3] = 1'b1;
    expect_release("R4 code4", 4096);
    wake_pin[3] = 1'b0; idle(4);
    wr(4'h4, 32'h0600_0000);
    wr(4'h0, 32'hA500_0001);
    wake_pin[3] = 1'b1;
    expect_release("R4 code6", 32768);
    wake_pin[3] = 1'b0; idle(4);
    rd(4'h8, v);

    // R5 R6 random pins, polarities and short codes
    for (int it = 0; it < 24; it++) begin
      int k, code;
      logic [15:0] pol, en;
      k = $urandom_range(15, 0);
      code = $urandom_range(2, 0);
      pol = 16'($urandom);
      en = 16'($urandom) | (16'd1 << k);
      wake_pin = ~pol;
      wr(4'h4, 32'(code) << 24);
      wr(4'hC, {pol, en});
      idle(4);
      wr(4'h0, 32'hA500_0001);
      idle(3);
      wake_pin[k] = pol[k];
      expect_release("R6 random", dbc_len(code));
      rd(4'h8, v); check("R5 random cause", v, 32'd1 << (16 + k));
      rd(4'h8, v); check("R8 random clear", v, 0);
      wake_pin[k] = ~pol[k];
      idle(4);
    end

    // R9 writing zero disables all sources
    wr(4'h4, 0); wr(4'hC, 0);
    wr(4'h0, 32'hA500_0001);
    wake_pin = 16'hFFFF; rtc_alarm = 1'b1; rtt_alarm = 1'b1; idle(10);
    check("R9 zeroed config", 32'(shdn_out), 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule